// File: doc/BRIEF.md
# Converter Serial Interface Sequencer

This block is the digital front end of a delta-sigma converter that talks to a host over two wires: one host-driven serial clock and one converter-driven line that both signals readiness and carries the result. An abstract modulator and filter deliver each new result with a one-cycle strobe. The block clamps it to a 24-bit two's complement word, holds the line high through a short update window, then pulls it low to say data is waiting. Each rising serial-clock edge then presents the next bit, most significant first.

The same two wires carry control. Extra serial-clock edges after the word request a calibration, and a serial clock held high for long enough powers the converter down until the clock drops again. Four select inputs (two channel bits, buffer enable and temperature-sensor enable) are watched: any change restarts the filter and keeps the line high for a full settling interval so that the first result shown is clean. The block drives three control pulses or levels toward the modulator: filter restart, calibrate and power-down. Every interval is a parameter counted in converter-clock cycles; the serial clock and the select inputs are synchronized into that domain before use.

Top module: `dsif_seq`

## Requirements
- R1: After reset the ready/data line is high, power-down is low and neither the restart nor the calibrate pulse is asserted.
- R2: When a result strobe is accepted, the line is high for UPD_CYC converter cycles (the update window) and then goes low to mark data ready.
- R3: Once ready, each synchronized serial-clock rising edge drives the next result bit onto the line, bit 23 first and bit 0 on the 24th edge.
- R4: The raw result (RAW_W bits, two's complement) is clamped: values above 8388607 read as 0x7FFFFF, values below -8388608 read as 0x800000, values in range read as their low 24 bits.
- R5: After the 24th edge the line holds bit 0; a 25th rising edge drives it high and it stays high.
- R6: A falling serial-clock edge after the 26th rising edge issues a one-cycle calibrate pulse; result strobes arriving within CAL_CYC cycles afterwards are discarded and the line stays high.
- R7: Any change on the four select inputs drives the line high, issues a one-cycle restart pulse, and discards result strobes for SETTLE_CYC cycles.
- R8: With data ready, a serial clock held high for STBY_CYC cycles raises power-down and keeps the line high; a low serial clock then clears power-down, pulses restart, and discards result strobes for WAKE_CYC cycles.
- R9: If 25 or more rising edges had been counted when power-down was entered, wakeup also issues a calibrate pulse and the discard interval is CAL_CYC instead of WAKE_CYC.
- R10: A result strobe arriving while data is ready replaces the word and reopens the update window with the line high; serial-clock edges during the update window do not shift bits.
- R11: Serial-clock edges while the line waits for a result (settling, calibrating or waking) have no effect on the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| chan_sel | input | 2 | Channel select inputs |
| buf_en | input | 1 | Input buffer enable select |
| temp_en | input | 1 | Temperature sensor select |
| conv_done | input | 1 | One-cycle strobe: a new raw result is on conv_raw |
| conv_raw | input | RAW_W | Raw signed filter result |
| drdy_dout | output | 1 | Ready (low) and serial data line |
| flt_restart | output | 1 | One-cycle pulse: restart the filter |
| cal_start | output | 1 | One-cycle pulse: begin self-calibration |
| pwr_down | output | 1 | Standby level to the modulator |

## Verification
The assertions assume the result strobe is a single-cycle pulse and that the host keeps each serial-clock level for at least two converter cycles, so no synchronized edge is lost. They also assume the select inputs sit still for two cycles after a change so that one change yields one restart. The stimulus holds every serial-clock phase for four cycles, keeps ordinary high phases far below the standby hold time, and moves one select input at a time between long quiet stretches.

// File: rtl/dsif_pkg.sv
package dsif_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // line high, waiting for an accepted result
        ST_UPD  = 2'd1,   // update window, line high, no shifting
        ST_DATA = 2'd2,   // result available, host may shift
        ST_STBY = 2'd3    // powered down
    } dsif_st_e;

endpackage

// File: rtl/dsif_sclk_sync.sv
module dsif_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic sclk_lvl,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sclk_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sclk_lvl  = sh_q[STAGES-1];
    assign sclk_rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign sclk_fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

    // a detected rise leaves the level high in the next cycle's history
    p_rise_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> sh_q[STAGES]);

endmodule

// File: rtl/dsif_sel_watch.sv
module dsif_sel_watch #(
    parameter int SEL_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    output logic             sel_chg
);

    logic [SEL_W-1:0] st_q [STAGES+1];
    logic [SEL_W-1:0] st_d [STAGES+1];

    always_comb begin
        st_d[0] = sel_in;
        for (int i = 1; i <= STAGES; i++) st_d[i] = st_q[i-1];
    end

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign sel_chg = (st_q[STAGES-1] != st_q[STAGES]);

endmodule

// File: rtl/dsif_sat.sv
module dsif_sat #(
    parameter int RAW_W  = 26,
    parameter int DATA_W = 24
) (
    input  logic [RAW_W-1:0]  raw,
    output logic [DATA_W-1:0] res
);

    localparam int XW = RAW_W - DATA_W + 1;

    generate
        if (RAW_W > DATA_W) begin : g_clamp
            logic [XW-1:0] top;
            logic          ovf;
            always_comb begin
                top = raw[RAW_W-1:DATA_W-1];
                ovf = !((&top) || (~|top));
                if (!ovf)               res = raw[DATA_W-1:0];
                else if (raw[RAW_W-1]) res = {1'b1, {(DATA_W-1){1'b0}}};
                else                    res = {1'b0, {(DATA_W-1){1'b1}}};
            end
        end else begin : g_pass
            assign res = raw[DATA_W-1:0];
        end
    endgenerate

    // the clamped word keeps the sign of the raw value
    always_comb begin
        p_sign_keep_r4: assert (res[DATA_W-1] == raw[RAW_W-1]);
    end

endmodule

// File: rtl/dsif_seq.sv
module dsif_seq
    import dsif_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int RAW_W      = 26,
    parameter int SYNC_STG   = 2,
    parameter int UPD_CYC    = 96,
    parameter int SETTLE_CYC = 52000,
    parameter int CAL_CYC    = 154400,
    parameter int WAKE_CYC   = 55600,
    parameter int STBY_CYC   = 16544
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic [1:0]       chan_sel,
    input  logic             buf_en,
    input  logic             temp_en,
    input  logic             conv_done,
    input  logic [RAW_W-1:0] conv_raw,
    output logic             drdy_dout,
    output logic             flt_restart,
    output logic             cal_start,
    output logic             pwr_down
);

    localparam int SEL_W  = 4;
    localparam int M1     = (UPD_CYC > SETTLE_CYC) ? UPD_CYC : SETTLE_CYC;
    localparam int M2     = (CAL_CYC > WAKE_CYC) ? CAL_CYC : WAKE_CYC;
    localparam int M3     = (M1 > M2) ? M1 : M2;
    localparam int TMAX   = (M3 > STBY_CYC) ? M3 : STBY_CYC;
    localparam int TMR_W  = $clog2(TMAX + 2);
    localparam int BIT_W  = $clog2(DATA_W + 3);
    localparam int N_DONE = DATA_W + 2;   // edges after which a falling edge calibrates
    localparam int N_CALW = DATA_W + 1;   // edges that arm calibration on wakeup

    typedef struct packed {
        dsif_st_e          st;
        logic [TMR_W-1:0]  tmr;
        logic [TMR_W-1:0]  blank;
        logic [TMR_W-1:0]  hold;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] word;
        logic              cal_pend;
        logic              pin;
        logic              restart;
        logic              cal;
        logic              pdn;
    } seq_t;

    seq_t r_q, r_d;

    logic              sclk_lvl, sclk_rise, sclk_fall;
    logic              sel_chg;
    logic [SEL_W-1:0]  sel_vec;
    logic [DATA_W-1:0] sat_word;
    logic [BIT_W-1:0]  bits_nx;

    assign sel_vec = {temp_en, buf_en, chan_sel};

    dsif_sclk_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk),
        .sclk_lvl  (sclk_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    dsif_sel_watch #(.SEL_W(SEL_W), .STAGES(SYNC_STG)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (sel_vec),
        .sel_chg (sel_chg)
    );

    dsif_sat #(.RAW_W(RAW_W), .DATA_W(DATA_W)) u_sat (
        .raw (conv_raw),
        .res (sat_word)
    );

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        r_d.cal     = 1'b0;
        bits_nx     = r_q.bits;

        if (sel_chg && (r_q.st != ST_STBY)) begin
            // select change: restart and blank for the settling interval
            r_d.st      = ST_WAIT;
            r_d.restart = 1'b1;
            r_d.blank   = TMR_W'(SETTLE_CYC);
            r_d.pin     = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    r_d.pin = 1'b1;
                    if (r_q.blank != '0) begin
                        r_d.blank = r_q.blank - 1'b1;
                    end else if (conv_done) begin
                        r_d.word = sat_word;
                        r_d.tmr  = TMR_W'(UPD_CYC);
                        r_d.st   = ST_UPD;
                    end
                end
                ST_UPD: begin
                    r_d.pin = 1'b1;
                    if (conv_done) begin
                        r_d.word = sat_word;
                        r_d.tmr  = TMR_W'(UPD_CYC);
                    end else if (r_q.tmr <= TMR_W'(1)) begin
                        r_d.st   = ST_DATA;
                        r_d.pin  = 1'b0;
                        r_d.bits = '0;
                        r_d.hold = '0;
                    end else begin
                        r_d.tmr = r_q.tmr - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (conv_done) begin
                        r_d.word = sat_word;
                        r_d.tmr  = TMR_W'(UPD_CYC);
                        r_d.st   = ST_UPD;
                        r_d.pin  = 1'b1;
                    end else if (sclk_fall && (r_q.bits == BIT_W'(N_DONE))) begin
                        r_d.st    = ST_WAIT;
                        r_d.cal   = 1'b1;
                        r_d.blank = TMR_W'(CAL_CYC);
                        r_d.pin   = 1'b1;
                    end else begin
                        if (sclk_rise) begin
                            if (r_q.bits < BIT_W'(DATA_W)) begin
                                r_d.pin  = r_q.word[DATA_W-1];
                                r_d.word = {r_q.word[DATA_W-2:0], 1'b0};
                            end else begin
                                r_d.pin = 1'b1;
                            end
                            if (r_q.bits < BIT_W'(N_DONE)) bits_nx = r_q.bits + 1'b1;
                        end
                        r_d.bits = bits_nx;
                        if (sclk_lvl) begin
                            if (r_q.hold >= TMR_W'(STBY_CYC - 1)) begin
                                r_d.st       = ST_STBY;
                                r_d.pdn      = 1'b1;
                                r_d.pin      = 1'b1;
                                r_d.cal_pend = (bits_nx >= BIT_W'(N_CALW));
                            end else begin
                                r_d.hold = r_q.hold + 1'b1;
                            end
                        end else begin
                            r_d.hold = '0;
                        end
                    end
                end
                ST_STBY: begin
                    r_d.pin = 1'b1;
                    r_d.pdn = 1'b1;
                    if (!sclk_lvl) begin
                        r_d.pdn      = 1'b0;
                        r_d.restart  = 1'b1;
                        r_d.st       = ST_WAIT;
                        r_d.cal_pend = 1'b0;
                        if (r_q.cal_pend) begin
                            r_d.cal   = 1'b1;
                            r_d.blank = TMR_W'(CAL_CYC);
                        end else begin
                            r_d.blank = TMR_W'(WAKE_CYC);
                        end
                    end
                end
                default: r_d.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_WAIT;
            r_q.pin <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drdy_dout   = r_q.pin;
    assign flt_restart = r_q.restart;
    assign cal_start   = r_q.cal;
    assign pwr_down    = r_q.pdn;

    // leaving the update window always shows the ready level
    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_UPD && r_q.st == ST_DATA) |-> !drdy_dout);

    // calibrate is a single-cycle pulse
    p_cal_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // restart is a single-cycle pulse
    p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_restart |=> !flt_restart);

    // a select change outside standby forces the line high and restarts
    p_sel_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chg && r_q.st != ST_STBY) |=> (drdy_dout && flt_restart));

    // while discarding, the block stays in the waiting phase
    p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && r_q.blank != '0 && !sel_chg) |=> r_q.st == ST_WAIT);

    // power-down never coexists with a low line
    p_pdn_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> drdy_dout);

    // the waiting phase never jumps straight to shifting
    p_wait_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |=> (r_q.st != ST_DATA));

endmodule

// File: tb/tb_dsif_seq.sv
module tb_dsif_seq;

    localparam int DATA_W = 24;
    localparam int RAW_W  = 26;
    localparam int UPD    = 12;
    localparam int SETTLE = 40;
    localparam int CAL    = 60;
    localparam int WAKE   = 30;
    localparam int STBY   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sclk = 1'b0;
    logic [1:0]       chan_sel = 2'b00;
    logic             buf_en = 1'b0;
    logic             temp_en = 1'b0;
    logic             conv_done = 1'b0;
    logic [RAW_W-1:0] conv_raw = '0;
    logic             drdy_dout, flt_restart, cal_start, pwr_down;

    int checks = 0;
    int failures = 0;
    int cal_cnt = 0;
    int rst_cnt = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic [DATA_W-1:0] act_q[$];

    always #5 clk = ~clk;

    dsif_seq #(
        .DATA_W(DATA_W), .RAW_W(RAW_W), .SYNC_STG(2),
        .UPD_CYC(UPD), .SETTLE_CYC(SETTLE), .CAL_CYC(CAL),
        .WAKE_CYC(WAKE), .STBY_CYC(STBY)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk),
        .chan_sel(chan_sel), .buf_en(buf_en), .temp_en(temp_en),
        .conv_done(conv_done), .conv_raw(conv_raw),
        .drdy_dout(drdy_dout), .flt_restart(flt_restart),
        .cal_start(cal_start), .pwr_down(pwr_down)
    );

    always @(negedge clk) begin
        if (cal_start)   cal_cnt++;
        if (flt_restart) rst_cnt++;
    end

    function automatic logic [DATA_W-1:0] sat_ref(input longint raw);
        if (raw > 64'sd8388607)       return 24'h7FFFFF;
        else if (raw < -64'sd8388608) return 24'h800000;
        else                          return raw[DATA_W-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv(input longint raw);
        @(negedge clk);
        conv_done = 1'b1;
        conv_raw  = raw[RAW_W-1:0];
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; wait_cyc(4);
        sclk = 1'b0; wait_cyc(4);
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (drdy_dout && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(!drdy_dout, tag, drdy_dout, 0);
    endtask

    task automatic read_word();
        logic [DATA_W-1:0] w = '0;
        for (int i = 0; i < DATA_W; i++) begin
            sclk = 1'b1; wait_cyc(4);
            w = {w[DATA_W-2:0], drdy_dout};
            sclk = 1'b0; wait_cyc(4);
        end
        act_q.push_back(w);
    endtask

    task automatic expect_word(input longint raw, input string tag);
        exp_q.push_back(sat_ref(raw));
        tag_q.push_back(tag);
    endtask

    // full transaction: result strobe, wait for ready, read 24 bits
    task automatic xfer(input longint raw, input string tag);
        expect_word(raw, tag);
        conv(raw);
        wait_ready(tag);
        read_word();
    endtask

    // monitor: compare every word read against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                logic [DATA_W-1:0] a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected word", a, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(a == e, t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c0, r0;
        wait_cyc(3);
        // R1: reset state
        check(drdy_dout == 1'b1, "R1 line high", drdy_dout, 1);
        check(pwr_down == 1'b0, "R1 power-down low", pwr_down, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        check(cal_cnt == 0 && rst_cnt == 0, "R1 no pulses", cal_cnt + rst_cnt, 0);

        // R2: update window timing
        expect_word(64'h123456, "R3 word 123456");
        conv(64'h123456);
        wait_cyc(UPD - 3);
        check(drdy_dout == 1'b1, "R2 high in window", drdy_dout, 1);
        wait_cyc(5);
        check(drdy_dout == 1'b0, "R2 low after window", drdy_dout, 0);
        read_word();
        // R5: hold LSB, then 25th edge forces high
        check(drdy_dout == 1'b0, "R5 holds bit 0", drdy_dout, 0);
        sclk_pulse();
        check(drdy_dout == 1'b1, "R5 25th edge high", drdy_dout, 1);

        // R3 / R4 patterns
        xfer(-64'sd5, "R4 in-range negative");
        xfer(64'h0A5A5A5 & 64'h7FFFFF, "R3 pattern 25A5A5");
        xfer(64'sd16777216, "R4 clamp high");
        xfer(-64'sd9000000, "R4 clamp low");
        xfer(64'sd8388607, "R4 max in range");
        check(drdy_dout == 1'b1, "R5 odd LSB holds high", drdy_dout, 1);

        // R10: overwrite while ready, edges in update window ignored
        conv(64'h111111);
        wait_ready("R10 first ready");
        expect_word(64'h2C3D4E, "R10 replaced word");
        conv(64'h2C3D4E);
        wait_cyc(1);
        check(drdy_dout == 1'b1, "R10 high on new strobe", drdy_dout, 1);
        sclk = 1'b1; wait_cyc(3);
        sclk = 1'b0; wait_cyc(3);
        wait_ready("R10 second ready");
        read_word();

        // R6: calibration via 26th falling edge
        xfer(64'h654321, "R6 before cal");
        sclk_pulse();
        c0 = cal_cnt;
        sclk_pulse();
        check(cal_cnt == c0 + 1, "R6 cal pulse", cal_cnt, c0 + 1);
        conv(64'h0F0F0F);
        wait_cyc(UPD + 8);
        check(drdy_dout == 1'b1, "R6 strobe discarded", drdy_dout, 1);
        wait_cyc(CAL);
        xfer(64'h3ABCDE, "R6 after cal");

        // R7 / R11: select change, edges during settling
        conv(64'h777777);
        wait_ready("R7 ready");
        r0 = rst_cnt;
        buf_en = 1'b1;
        wait_cyc(5);
        check(drdy_dout == 1'b1, "R7 line high", drdy_dout, 1);
        check(rst_cnt == r0 + 1, "R7 restart pulse", rst_cnt, r0 + 1);
        sclk_pulse();
        sclk_pulse();
        conv(64'h0EEEEE);
        wait_cyc(UPD + 3);
        check(drdy_dout == 1'b1, "R7 strobe discarded", drdy_dout, 1);
        wait_cyc(SETTLE);
        xfer(64'h1D2E3F, "R11 word after settle");

        // R8: standby without calibration
        conv(64'h00ABCD);
        wait_ready("R8 ready");
        r0 = rst_cnt;
        c0 = cal_cnt;
        sclk = 1'b1;
        wait_cyc(STBY + 10);
        check(pwr_down == 1'b1, "R8 power-down", pwr_down, 1);
        check(drdy_dout == 1'b1, "R8 line high", drdy_dout, 1);
        sclk = 1'b0;
        wait_cyc(5);
        check(pwr_down == 1'b0, "R8 wake", pwr_down, 0);
        check(rst_cnt == r0 + 1, "R8 restart on wake", rst_cnt, r0 + 1);
        check(cal_cnt == c0, "R8 no cal", cal_cnt, c0);
        conv(64'h0DDDDD);
        wait_cyc(UPD + 3);
        check(drdy_dout == 1'b1, "R8 strobe discarded", drdy_dout, 1);
        wait_cyc(WAKE);
        xfer(64'h456789, "R8 word after wake");

        // R9: standby after 25 edges calibrates on wake
        xfer(64'h2468AC, "R9 before standby");
        sclk_pulse();
        c0 = cal_cnt;
        sclk = 1'b1;
        wait_cyc(STBY + 10);
        check(pwr_down == 1'b1, "R9 power-down", pwr_down, 1);
        sclk = 1'b0;
        wait_cyc(5);
        check(cal_cnt == c0 + 1, "R9 cal on wake", cal_cnt, c0 + 1);
        wait_cyc(WAKE + 5);
        conv(64'h0CCCCC);
        wait_cyc(UPD + 3);
        check(drdy_dout == 1'b1, "R9 strobe discarded", drdy_dout, 1);
        wait_cyc(CAL);
        xfer(64'h13579B, "R9 word after cal");

        wait_cyc(10);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule